// File: doc/BRIEF.md
# Interrupt Status, Mask and Clear Unit

This block gathers the event lines of a peripheral core into one interrupt request. Each event line owns one sticky raw flag. A flag is captured when its event line is asserted, or on its rising edge when the edge variant is chosen. The flag stays set until software removes it. A per-flag enable mask gates the raw flags into a masked view, and the request output is asserted whenever any masked flag is set.

Software reaches the block through a plain single-cycle register port. It has a select, a write strobe, an address and write data. Read data is combinational and depends on the address. Four word registers sit at fixed offsets from a base address, which defaults to 0xFF00. The raw view and the masked view are read-only. The enable mask can be written and read. A clear register is write-only, and every one bit written to it removes the matching raw flag.

Top module: `isc_irq_unit`

## Requirements
- R1: After reset all raw flags and all mask bits are zero, `irq_o` is low, and a read of any of the four registers returns zero.
- R2: With `EDGE_CAPTURE=0`, a raw flag is set on the clock edge at which its event bit is high. It then holds until it is cleared.
- R3: A read (`bus_sel=1`, `bus_wr=0`) at BASE+0x0 returns the raw flags in bits [NUM_FLAGS-1:0]. The bits above them read as zero.
- R4: A write at BASE+0x4 stores `bus_wdata[NUM_FLAGS-1:0]` as the mask. A read at BASE+0x4 returns it, with zeros above.
- R5: A read at BASE+0x8 returns the bitwise AND of the raw flags and the mask.
- R6: A write at BASE+0xC clears each raw flag whose `bus_wdata` bit is 1 and leaves the flags under 0 bits untouched. A read at BASE+0xC returns zero.
- R7: When a flag's set condition and its clear bit occur on the same clock edge, the flag ends up set.
- R8: `irq_o` is high exactly when at least one flag is both raw-set and enabled in the mask. A flag whose mask bit is 0 cannot raise it.
- R9: Writes to BASE+0x0, BASE+0x8 or any unmapped address change neither the raw flags nor the mask. Reads of unmapped addresses, idle cycles and write cycles all return zero.
- R10: With `EDGE_CAPTURE=1`, a raw flag is set only on a 0-to-1 transition of its event bit. An event bit that stays high after its flag is cleared does not set the flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_FLAGS | Event lines from the peripheral core, one per flag |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds two copies of the block side by side, with four flags, 32-bit data and 16-bit addresses at base 0xFF00. One copy uses level capture and the other uses edge capture. Both copies see the same stimulus. A level held across a clear therefore sets the flag again in one copy and not in the other, and that difference is visible in the same cycle. Four flags are few enough that random event and clear patterns often collide on one bit, so set-versus-clear races and masks that hide every pending flag come up often. A fifth address slot just past the block checks that unmapped accesses are ignored.

// File: rtl/isc_pkg.sv
package isc_pkg;

   localparam int OFS_RAW  = 'h0;
   localparam int OFS_MASK = 'h4;
   localparam int OFS_MIS  = 'h8;
   localparam int OFS_CLR  = 'hC;

   typedef struct packed {
      logic raw;
      logic mask;
      logic mis;
      logic clr;
   } isc_hit_t;

endpackage

// File: rtl/isc_addr_decode.sv
module isc_addr_decode #(
   parameter int                 ADDR_W    = 16,
   parameter logic [ADDR_W-1:0]  BASE_ADDR = 'hFF00
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_sel,
   input  logic                  bus_wr,
   input  logic [ADDR_W-1:0]     bus_addr,
   output isc_pkg::isc_hit_t     hit,
   output logic                  rd_en,
   output logic                  wr_en
);
   import isc_pkg::*;

   localparam logic [ADDR_W-1:0] A_RAW  = BASE_ADDR + ADDR_W'(OFS_RAW);
   localparam logic [ADDR_W-1:0] A_MASK = BASE_ADDR + ADDR_W'(OFS_MASK);
   localparam logic [ADDR_W-1:0] A_MIS  = BASE_ADDR + ADDR_W'(OFS_MIS);
   localparam logic [ADDR_W-1:0] A_CLR  = BASE_ADDR + ADDR_W'(OFS_CLR);

   if (ADDR_W < 4) begin : g_bad_addr_w
      $error("isc_addr_decode: ADDR_W must be at least 4");
   end
   if (BASE_ADDR[3:0] != 4'h0) begin : g_bad_base
      $error("isc_addr_decode: BASE_ADDR must be 16-byte aligned");
   end

   always_comb begin
      hit      = '0;
      hit.raw  = bus_sel && (bus_addr == A_RAW);
      hit.mask = bus_sel && (bus_addr == A_MASK);
      hit.mis  = bus_sel && (bus_addr == A_MIS);
      hit.clr  = bus_sel && (bus_addr == A_CLR);
   end

   assign rd_en = bus_sel && !bus_wr;
   assign wr_en = bus_sel &&  bus_wr;

   // R9: at most one register is addressed in any cycle
   a_r9_one_target: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({hit.raw, hit.mask, hit.mis, hit.clr}));

   // R9: no register is addressed without a select
   a_r9_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_sel |-> (hit == '0));

endmodule

// File: rtl/isc_flag_capture.sv
module isc_flag_capture #(
   parameter int NUM_FLAGS    = 4,
   parameter bit EDGE_CAPTURE = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_FLAGS-1:0] evt_i,
   input  logic [NUM_FLAGS-1:0] clr_i,
   output logic [NUM_FLAGS-1:0] raw_o
);

   logic [NUM_FLAGS-1:0] set_v;

   if (NUM_FLAGS < 1) begin : g_bad_n
      $error("isc_flag_capture: NUM_FLAGS must be at least 1");
   end

   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
      if (EDGE_CAPTURE) begin : g_edge
         logic evt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) evt_q <= 1'b0;
            else        evt_q <= evt_i[i];
         end
         assign set_v[i] = evt_i[i] && !evt_q;
      end else begin : g_level
         assign set_v[i] = evt_i[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          raw_o[i] <= 1'b0;
         else if (set_v[i])   raw_o[i] <= 1'b1;
         else if (clr_i[i])   raw_o[i] <= 1'b0;
      end

      // R2: a pending flag without a clear stays pending
      a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (raw_o[i] && !clr_i[i]) |=> raw_o[i]);

      // R7: set beats clear on the same edge
      a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         (set_v[i] && clr_i[i]) |=> raw_o[i]);

      // R6: a clear with no competing set empties the flag
      a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[i] && !set_v[i]) |=> !raw_o[i]);

      // R10 / R2: a flag only rises when its event line is high
      a_r10_rise_needs_evt: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(raw_o[i]) |-> $past(evt_i[i]));
   end

endmodule

// File: rtl/isc_read_mux.sv
module isc_read_mux #(
   parameter int NUM_FLAGS = 4,
   parameter int DATA_W    = 32
) (
   input  logic                 rd_en,
   input  isc_pkg::isc_hit_t    hit,
   input  logic [NUM_FLAGS-1:0] raw_i,
   input  logic [NUM_FLAGS-1:0] mask_i,
   output logic [DATA_W-1:0]    rdata_o
);

   logic [NUM_FLAGS-1:0] sel_v;

   if (NUM_FLAGS > DATA_W) begin : g_bad_width
      $error("isc_read_mux: NUM_FLAGS must not exceed DATA_W");
   end

   always_comb begin
      sel_v = '0;
      if (rd_en) begin
         if (hit.raw)  sel_v = raw_i;
         if (hit.mask) sel_v = mask_i;
         if (hit.mis)  sel_v = raw_i & mask_i;
      end
   end

   if (NUM_FLAGS == DATA_W) begin : g_full
      assign rdata_o = sel_v;
   end else begin : g_pad
      assign rdata_o = {{(DATA_W-NUM_FLAGS){1'b0}}, sel_v};
   end

   // R6 / R9: the clear slot never returns data
   always_comb begin
      if (rd_en && hit.clr) a_r6_clr_reads_zero: assert (rdata_o == '0);
   end

endmodule

// File: rtl/isc_irq_unit.sv
module isc_irq_unit #(
   parameter int                 NUM_FLAGS    = 4,
   parameter int                 DATA_W       = 32,
   parameter int                 ADDR_W       = 16,
   parameter logic [ADDR_W-1:0]  BASE_ADDR    = 'hFF00,
   parameter bit                 EDGE_CAPTURE = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_FLAGS-1:0] evt_i,
   input  logic                 bus_sel,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   output logic                 irq_o
);
   import isc_pkg::*;

   isc_hit_t             hit;
   logic                 rd_en;
   logic                 wr_en;
   logic                 mask_we;
   logic [NUM_FLAGS-1:0] mask_q;
   logic [NUM_FLAGS-1:0] clr_v;
   logic [NUM_FLAGS-1:0] raw_q;

   if (NUM_FLAGS < 1 || NUM_FLAGS > DATA_W) begin : g_bad_flags
      $error("isc_irq_unit: NUM_FLAGS must lie in 1..DATA_W");
   end

   isc_addr_decode #(
      .ADDR_W    (ADDR_W),
      .BASE_ADDR (BASE_ADDR)
   ) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_sel  (bus_sel),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .hit      (hit),
      .rd_en    (rd_en),
      .wr_en    (wr_en)
   );

   assign mask_we = wr_en && hit.mask;
   assign clr_v   = (wr_en && hit.clr) ? bus_wdata[NUM_FLAGS-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '0;
      else if (mask_we) mask_q <= bus_wdata[NUM_FLAGS-1:0];
   end

   isc_flag_capture #(
      .NUM_FLAGS    (NUM_FLAGS),
      .EDGE_CAPTURE (EDGE_CAPTURE)
   ) u_cap (
      .clk   (clk),
      .rst_n (rst_n),
      .evt_i (evt_i),
      .clr_i (clr_v),
      .raw_o (raw_q)
   );

   isc_read_mux #(
      .NUM_FLAGS (NUM_FLAGS),
      .DATA_W    (DATA_W)
   ) u_rd (
      .rd_en   (rd_en),
      .hit     (hit),
      .raw_i   (raw_q),
      .mask_i  (mask_q),
      .rdata_o (bus_rdata)
   );

   assign irq_o = |(raw_q & mask_q);

   // R4 / R9: the mask moves only on a write to its own slot
   a_r4_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_we |=> $stable(mask_q));

   // R4: a mask write lands on the next edge
   a_r4_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
      mask_we |=> (mask_q == $past(bus_wdata[NUM_FLAGS-1:0])));

   // R8: a request needs both a pending flag and an enable
   a_r8_irq_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (raw_q != '0) && (mask_q != '0));

   // R9: writes into a read-only view do not touch any flag's clear
   a_r9_ro_write_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (hit.raw || hit.mis)) |-> (clr_v == '0));

endmodule

// File: tb/isc_irq_unit_tb.sv
`timescale 1ns/1ps
module isc_irq_unit_tb;

   localparam int N  = 4;
   localparam int DW = 32;
   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  evt = '0;
   logic          sel = 1'b0;
   logic          wr = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rd_l, rd_e;
   logic          irq_l, irq_e;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   isc_irq_unit #(.NUM_FLAGS(N), .DATA_W(DW), .ADDR_W(AW),
                  .BASE_ADDR(16'hFF00), .EDGE_CAPTURE(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .bus_sel(sel), .bus_wr(wr),
      .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rd_l), .irq_o(irq_l));

   isc_irq_unit #(.NUM_FLAGS(N), .DATA_W(DW), .ADDR_W(AW),
                  .BASE_ADDR(16'hFF00), .EDGE_CAPTURE(1'b1)) u_dut_edg (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .bus_sel(sel), .bus_wr(wr),
      .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rd_e), .irq_o(irq_e));

   // behavioural reference model
   int m_raw_l, m_raw_e, m_prev, m_mask;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_raw_l <= 0; m_raw_e <= 0; m_prev <= 0; m_mask <= 0;
      end else begin : upd
         int ev, clr;
         ev  = int'(evt);
         clr = (sel && wr && addr == 16'hFF0C) ? int'(wdata[N-1:0]) : 0;
         m_raw_l <= ev | (m_raw_l & ~clr);
         m_raw_e <= (ev & ~m_prev) | (m_raw_e & ~clr);
         m_prev  <= ev;
         if (sel && wr && addr == 16'hFF04) m_mask <= int'(wdata[N-1:0]);
      end
   end

   function automatic int exp_rd(int raw, int mask);
      if (!sel || wr) return 0;
      case (addr)
         16'hFF00: return raw;
         16'hFF04: return mask;
         16'hFF08: return raw & mask;
         default:  return 0;
      endcase
   endfunction

   function automatic string tag_of();
      if (!sel || wr) return "R9";
      case (addr)
         16'hFF00: return "R3";
         16'hFF04: return "R4";
         16'hFF08: return "R5";
         16'hFF0C: return "R6";
         default:  return "R9";
      endcase
   endfunction

   task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
      end
   endtask

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         chk(tag_of(), rd_l, DW'(exp_rd(m_raw_l, m_mask)));
         chk(tag_of(), rd_e, DW'(exp_rd(m_raw_e, m_mask)));
         chk("R8", DW'(irq_l), DW'((m_raw_l & m_mask) != 0));
         chk("R8", DW'(irq_e), DW'((m_raw_e & m_mask) != 0));
      end
   end

   task automatic cyc(logic [N-1:0] e, logic s, logic w,
                      logic [AW-1:0] a, logic [DW-1:0] d);
      @(posedge clk); #1;
      evt = e; sel = s; wr = w; addr = a; wdata = d;
   endtask

   task automatic look(string tag, logic [DW-1:0] exp_l, logic [DW-1:0] exp_e);
      @(negedge clk); #1;
      chk(tag, rd_l, exp_l);
      chk(tag, rd_e, exp_e);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      cyc(4'h0, 1, 0, 16'hFF00, 0); look("R1", 0, 0);
      chk("R1", DW'(irq_l), 0);
      cyc(4'h0, 1, 0, 16'hFF04, 0); look("R1", 0, 0);

      // R2: event captured and held
      cyc(4'h1, 0, 0, 16'h0000, 0);
      cyc(4'h0, 1, 0, 16'hFF00, 0); look("R2", 1, 1);
      cyc(4'h0, 1, 0, 16'hFF00, 0); look("R2", 1, 1);

      // R4, R5, R8: enable bits 0 and 2
      cyc(4'h0, 1, 1, 16'hFF04, 32'hFFFF_FFF5);
      cyc(4'h0, 1, 0, 16'hFF04, 0); look("R4", 5, 5);
      cyc(4'h0, 1, 0, 16'hFF08, 0); look("R5", 1, 1);
      chk("R8", DW'(irq_l), 1);

      // R6: write-one clear, then clear slot reads zero
      cyc(4'h0, 1, 1, 16'hFF0C, 32'h1);
      cyc(4'h0, 1, 0, 16'hFF00, 0); look("R6", 0, 0);
      chk("R6", DW'(irq_l), 0);
      cyc(4'h0, 1, 0, 16'hFF0C, 0); look("R6", 0, 0);

      // R7: set and clear on the same edge
      cyc(4'h2, 1, 1, 16'hFF0C, 32'h2);
      cyc(4'h0, 1, 0, 16'hFF00, 0); look("R7", 2, 2);

      // R9: writes to read-only and unmapped slots are ignored
      cyc(4'h0, 1, 1, 16'hFF00, 32'hF);
      cyc(4'h0, 1, 1, 16'hFF08, 32'hF);
      cyc(4'h0, 1, 1, 16'hFF10, 32'h0);
      cyc(4'h0, 1, 0, 16'hFF00, 0); look("R9", 2, 2);
      cyc(4'h0, 1, 0, 16'hFF04, 0); look("R9", 5, 5);
      cyc(4'h0, 1, 0, 16'hFF10, 0); look("R9", 0, 0);
      chk("R8", DW'(irq_l), 0);

      // R10: held level refills level copy but not edge copy
      cyc(4'h4, 0, 0, 16'h0000, 0);
      cyc(4'h4, 1, 1, 16'hFF0C, 32'h4);
      cyc(4'h4, 1, 0, 16'hFF00, 0); look("R10", 6, 2);
      cyc(4'h0, 1, 1, 16'hFF0C, 32'hF);

      // random traffic, compared every cycle by the model
      for (int k = 0; k < 2000; k++) begin
         cyc(N'($urandom & $urandom), 1'($urandom), 1'($urandom),
             16'hFF00 + AW'(4 * ($urandom % 5)), $urandom);
      end
      cyc(4'h0, 0, 0, 16'h0000, 0);
      @(negedge clk); #1;
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule